// File: doc/BRIEF.md
# Constant-Coefficient Folded-Table Multiplier

This block multiplies a 7-bit unsigned operand by an unsigned coefficient fixed at elaboration time. It uses a small precomputed table instead of a multiplier array. The operand is folded about its midpoint: the upper half is used as it is, and the lower half is replaced by its distance to 64. The product is then 64A plus the folded multiple for upper-half operands, or 64A minus it for lower-half operands.

The folded multiple is found by removing the trailing zeros of the folded operand. The odd value that remains indexes a table of odd multiples of A, and a logarithmic left shifter restores the removed power of two. The table holds 33 words: the 32 odd multiples A·1 through A·63 and one extra word 2A. The extra word serves operand 0, where 2A shifted five places gives exactly 64A. Operand 64 instead forces the table word to zero. All table words are computed from the coefficient parameter.

The result is available on the next clock edge when the output register is enabled, which is the default. With the register disabled, the result is available in the same cycle.

Top module: `const_lut_mul`

## Requirements
- R1: With REGISTER_OUT=1, `prod_out` equals `x_in` × COEF, as an exact unsigned product, one clock edge after `x_in` is applied.
- R2: For operands 65 to 127 (bit 6 set, low bits nonzero), the product is formed by adding to 64·COEF and equals `x_in` × COEF.
- R3: For operands 1 to 63 (bit 6 clear), the product is formed by subtracting a multiple of COEF from 64·COEF and equals `x_in` × COEF.
- R4: Operand 64 gives exactly 64·COEF, with the table word forced to zero.
- R5: Operand 0 gives 0. The special word 2·COEF is shifted left five places and subtracted from 64·COEF.
- R6: The left shift applied to the table word never exceeds five places, and it is zero whenever the operand is odd. Powers of two and other even operands give exact products.
- R7: While `rst_n` is low, `prod_out` is 0.
- R8: The 19-bit product does not overflow for any operand when COEF = 4095, the all-ones value. The product is also correct for COEF = 0 and for odd and even coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_in | input | 7 | Unsigned operand |
| prod_out | output | 19 | Unsigned product x_in × COEF |

## Verification
Two sets of paths can be exercised in the same cycle. In the first, the zero-forcing of the table word meets the add path at operand 64. In the second, the special 2A word with its five-place shift meets the subtract path at operand 0. The sweep applies every operand in order, one per cycle, so the operand sequence 63, 64, 65 moves across the fold boundary on consecutive edges. The sequence 127 then 0 follows at the wrap. Each result is popped from a queue of expected values and compared against an independent product X·A, for five coefficients side by side.

// File: rtl/const_lut_mul.sv
module const_lut_mul #(
  parameter int COEF_W = 12,
  parameter int IN_W   = 7,
  parameter logic [COEF_W-1:0] COEF = 12'd2731,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IN_W-1:0]        x_in,
  output logic [COEF_W+IN_W-1:0] prod_out
);
  localparam int FW   = IN_W - 1;
  localparam int NODD = 1 << (FW - 1);
  localparam int TW   = COEF_W + FW;
  localparam int PW   = COEF_W + IN_W;
  localparam int SW   = $clog2(FW);

  logic          top;
  logic [FW-1:0] low, fold, odd_val, addr;
  logic [SW-1:0] tz, shamt;
  logic          special, zero_word;
  logic [TW-1:0] word;
  logic [TW-1:0] stage [0:SW];
  logic [TW-1:0] table_mem [0:NODD];
  logic [PW-1:0] base, prod_c;

  assign top  = x_in[IN_W-1];
  assign low  = x_in[FW-1:0];
  assign fold = top ? low : (~low + FW'(1));

  assign special   = (fold == '0) && !top;
  assign zero_word = (fold == '0) && top;

  always_comb begin
    tz = '0;
    for (int k = FW - 1; k >= 0; k--)
      if (fold[k]) tz = SW'(k);
  end

  assign odd_val = fold >> tz;
  assign addr    = special ? FW'(NODD) : {1'b0, odd_val[FW-1:1]};
  assign shamt   = special ? SW'(FW - 1) : tz;

  for (genvar i = 0; i < NODD; i++) begin : g_odd
    assign table_mem[i] = TW'(COEF) * TW'(2 * i + 1);
  end
  assign table_mem[NODD] = TW'(COEF) << 1;

  assign word     = zero_word ? '0 : table_mem[addr];
  assign stage[0] = word;
  for (genvar s = 0; s < SW; s++) begin : g_shift
    assign stage[s+1] = shamt[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign base   = PW'(COEF) << FW;
  assign prod_c = top ? base + PW'(stage[SW]) : base - PW'(stage[SW]);

  if (REGISTER_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prod_out <= '0;
      else        prod_out <= prod_c;
  end else begin : g_comb
    assign prod_out = prod_c;
  end
endmodule

module const_lut_mul_chk #(
  parameter int COEF_W = 12,
  parameter int IN_W   = 7,
  parameter logic [COEF_W-1:0] COEF = 12'd2731,
  parameter bit REGISTER_OUT = 1'b1,
  parameter int SW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [IN_W-1:0]        x_in,
  input logic [COEF_W+IN_W-1:0] prod_out,
  input logic [SW-1:0]          shamt,
  input logic                   special,
  input logic                   zero_word
);
  localparam int PW = COEF_W + IN_W;
  localparam int FW = IN_W - 1;
  localparam logic [PW-1:0] MID = PW'(COEF) << FW;

  p_shift_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(shamt) <= FW - 1);
  p_odd_noshift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    x_in[0] |-> (shamt == '0));
  p_special_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    special |-> (x_in == '0));
  p_zero_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_word |-> (x_in == IN_W'(1 << FW)));

  if (REGISTER_OUT) begin : g_seq
    p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> prod_out == PW'($past(x_in)) * PW'(COEF));
    p_zero_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (x_in == '0) |=> (prod_out == '0));
    p_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (x_in == IN_W'(1 << FW)) |=> (prod_out == MID));
    p_reset_r7: assert property (@(posedge clk)
      !rst_n |-> (prod_out == '0));
  end else begin : g_cmb
    p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
      prod_out == PW'(x_in) * PW'(COEF));
    p_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (x_in == IN_W'(1 << FW)) |-> (prod_out == MID));
  end
endmodule

bind const_lut_mul const_lut_mul_chk #(
  .COEF_W(COEF_W), .IN_W(IN_W), .COEF(COEF),
  .REGISTER_OUT(REGISTER_OUT), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .x_in(x_in), .prod_out(prod_out),
  .shamt(shamt), .special(special), .zero_word(zero_word)
);

// File: tb/const_lut_mul_bench.sv
module const_lut_mul_bench;
  localparam int COEF_W = 12;
  localparam int IN_W   = 7;
  localparam int PW     = COEF_W + IN_W;
  localparam int NC     = 5;
  localparam logic [COEF_W-1:0] COEFS [NC] = '{12'd0, 12'd1, 12'd2731, 12'd1000, 12'd4095};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IN_W-1:0] x_in = '0;
  logic [PW-1:0] prod [NC];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [IN_W-1:0] exp_q [$];

  always #5 clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : g_dut
    const_lut_mul #(.COEF_W(COEF_W), .IN_W(IN_W), .COEF(COEFS[g]), .REGISTER_OUT(1'b1))
      u_const_lut_mul (.clk(clk), .rst_n(rst_n), .x_in(x_in), .prod_out(prod[g]));
  end

  function automatic string req_of(logic [IN_W-1:0] x, int c);
    if (COEFS[c] == 12'd4095) return "R8";
    if (x == 0)  return "R5";
    if (x == 64) return "R4";
    if ((x & (x - 1)) == 0) return "R6";
    if (x > 64)  return "R2";
    return "R3";
  endfunction

  task automatic drive(input logic [IN_W-1:0] x);
    @(negedge clk);
    x_in = x;
    exp_q.push_back(x);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      logic [IN_W-1:0] x;
      x = exp_q.pop_front();
      for (int c = 0; c < NC; c++) begin
        logic [PW-1:0] e;
        e = PW'(x) * PW'(COEFS[c]);
        checks++;
        if (prod[c] !== e) begin
          fails++;
          $display("FAIL %s (R1) coef=%0d x=%0d actual=%0d expected=%0d",
                   req_of(x, c), COEFS[c], x, prod[c], e);
        end
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    x_in = 7'd99;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (prod[c] !== '0) begin
        fails++;
        $display("FAIL R7 reset coef=%0d actual=%0d expected=0", COEFS[c], prod[c]);
      end
    end
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) drive(IN_W'(i));
    drive(7'd0);
    drive(7'd64);
    drive(7'd63);
    drive(7'd64);
    drive(7'd0);
    drive(7'd127);
    drive(7'd32);
    drive(7'd96);
    drive(7'd1);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule